// File: doc/BRIEF.md
# Fractional RTC Rate Trim Divider

This divider turns an oversampled crystal clock enable, nominally 8 x 32768 Hz, into a one-second tick and four quarter-second ticks. The length of each second can be trimmed in single-cycle steps of the fast clock. Each second is split into four quarters. A 17-bit count P sets the base length of every quarter. A 2-bit count Q picks how many quarters, taken from the start of the second, are stretched by one extra cycle. A second therefore lasts 4*P+Q enabled cycles. Over a 262144-cycle second, one cycle is about 3.8 ppm of rate. A trim for a shift of d ppm is chosen as round(262144/(1+d*1e-6)). For example, 4P+Q = 262403 (P=0x10040, Q=3) slows the tick by about 988 ppm.

New trim values are staged and take effect only at a second boundary, so no quarter is ever cut short. P values too small to run the counter safely are raised to a floor. Two calibration outputs allow the tick rate to be measured with a frequency counter. One has a 1 s period and the other a 4 s period, and both are high for about a quarter of their period.

Top module: `rtc_trim_divider`

## Requirements
- R1: After reset qtr_tick and sec_tick are 0, pulse_1s and pulse_4s are 1, and the active trim is P=0x10000, Q=0. The first qtr_tick therefore follows the 65536th enabled cycle after reset.
- R2: The divider advances only on clock edges where ce is 1. While ce is 0, no tick is produced and pulse_1s and pulse_4s hold their values.
- R3: Within a second, quarters 0 to Q-1 last P+1 enabled cycles and the remaining quarters last P cycles, so a second lasts 4*P+Q enabled cycles.
- R4: qtr_tick is high for exactly one clock, in the cycle after the edge that completes a quarter. sec_tick is high together with the qtr_tick that closes quarter 3.
- R5: A trim_load stores trim_p and trim_q as pending values, and the pending values become active at the next second boundary. If several loads happen in one second, the last one wins. A load in the cycle of a boundary edge takes effect at that same boundary.
- R6: pulse_1s is 1 while the divider is in quarter 0 of a second and 0 in quarters 1 to 3, giving a 1 s period with 25% duty.
- R7: pulse_4s is 1 during second 0 of each group of four seconds and 0 during seconds 1 to 3, giving a 4 s period with 25% duty.
- R8: A loaded trim_p below 4 is treated as 4. For example, P=1, Q=0 gives a 16-cycle second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Oversampled crystal clock enable, one pulse per 1/262144 s nominal |
| trim_load | input | 1 | Strobe that stages trim_p and trim_q |
| trim_p | input | 17 | Cycles per quarter |
| trim_q | input | 2 | Number of leading quarters stretched by one cycle |
| sec_tick | output | 1 | One-clock pulse at each second boundary |
| qtr_tick | output | 1 | One-clock pulse at each quarter boundary |
| pulse_1s | output | 1 | Calibration output, high in quarter 0 |
| pulse_4s | output | 1 | Calibration output, high in second 0 of four |

## Verification
A wrong cycle count or quarter index appears at the ports as a qtr_tick that is early or late, seen at the very next quarter boundary. Because the per-clock reference compares every output on every clock, the error is caught within one quarter. A wrong active trim changes the interval between sec_tick pulses and is seen at the end of the first second after the boundary where it was applied. A slip in the group counter shows on pulse_4s at the next second boundary.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam int unsigned TRIM_P_W = 17;
  localparam int unsigned TRIM_Q_W = 2;

  // raise a trim count that is too small to a safe floor
  function automatic int unsigned clamp_p(input int unsigned p, input int unsigned p_min);
    return (p < p_min) ? p_min : p;
  endfunction

  // length of quarter idx of a second, in enabled cycles
  function automatic int unsigned quarter_len(input int unsigned p, input int unsigned q,
                                              input int unsigned idx);
    return p + ((idx < q) ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/rtc_trim_stage.sv
module rtc_trim_stage
  import rtc_trim_pkg::*;
#(
  parameter int unsigned P_W     = TRIM_P_W,
  parameter int unsigned Q_W     = TRIM_Q_W,
  parameter logic [P_W-1:0] P_RESET = P_W'(32'h10000),
  parameter int unsigned P_MIN   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sec_end,
  input  logic           trim_load,
  input  logic [P_W-1:0] trim_p,
  input  logic [Q_W-1:0] trim_q,
  output logic [P_W-1:0] act_p,
  output logic [Q_W-1:0] act_q
);

  logic [P_W-1:0] pend_p;
  logic [Q_W-1:0] pend_q;
  logic [P_W-1:0] safe_p;

  assign safe_p = P_W'(clamp_p(32'(trim_p), P_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_p <= P_RESET;
      pend_q <= '0;
      act_p  <= P_RESET;
      act_q  <= '0;
    end else begin
      if (trim_load) begin
        pend_p <= safe_p;
        pend_q <= trim_q;
      end
      if (sec_end) begin
        act_p <= trim_load ? safe_p : pend_p;
        act_q <= trim_load ? trim_q : pend_q;
      end
    end
  end

endmodule

// File: rtl/rtc_quarter_count.sv
module rtc_quarter_count
  import rtc_trim_pkg::*;
#(
  parameter int unsigned P_W = TRIM_P_W,
  parameter int unsigned Q_W = TRIM_Q_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [P_W-1:0] act_p,
  input  logic [Q_W-1:0] act_q,
  output logic [Q_W-1:0] qtr_idx,
  output logic           qtr_end,
  output logic           sec_end
);

  localparam int unsigned C_W = P_W + 1;
  localparam int unsigned NQ  = 1 << Q_W;

  logic [C_W-1:0] cyc_cnt;
  logic [C_W-1:0] cur_len;
  logic           last_cyc;

  assign cur_len  = C_W'(quarter_len(32'(act_p), 32'(act_q), 32'(qtr_idx)));
  assign last_cyc = (cyc_cnt + C_W'(1)) >= cur_len;
  assign qtr_end  = ce && last_cyc;
  assign sec_end  = qtr_end && (qtr_idx == Q_W'(NQ - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      qtr_idx <= '0;
    end else if (ce) begin
      if (last_cyc) begin
        cyc_cnt <= '0;
        qtr_idx <= qtr_idx + Q_W'(1);
      end else begin
        cyc_cnt <= cyc_cnt + C_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_cal_out.sv
module rtc_cal_out #(
  parameter int unsigned Q_W = 2,
  parameter int unsigned G_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           qtr_end,
  input  logic           sec_end,
  input  logic [Q_W-1:0] qtr_idx,
  output logic           qtr_tick,
  output logic           sec_tick,
  output logic           pulse_1s,
  output logic           pulse_4s
);

  logic [G_W-1:0] sec_grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtr_tick <= 1'b0;
      sec_tick <= 1'b0;
      sec_grp  <= '0;
    end else begin
      qtr_tick <= qtr_end;
      sec_tick <= sec_end;
      if (sec_end) sec_grp <= sec_grp + G_W'(1);
    end
  end

  assign pulse_1s = (qtr_idx == '0);
  assign pulse_4s = (sec_grp == '0);

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int unsigned P_W     = TRIM_P_W,
  parameter int unsigned Q_W     = TRIM_Q_W,
  parameter int unsigned G_W     = 2,
  parameter logic [P_W-1:0] P_RESET = P_W'(32'h10000),
  parameter int unsigned P_MIN   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic           trim_load,
  input  logic [P_W-1:0] trim_p,
  input  logic [Q_W-1:0] trim_q,
  output logic           sec_tick,
  output logic           qtr_tick,
  output logic           pulse_1s,
  output logic           pulse_4s
);

  // internal events, named for the checker
  logic [P_W-1:0] act_p;
  logic [Q_W-1:0] act_q;
  logic [Q_W-1:0] qtr_idx;
  logic           qtr_end;
  logic           sec_end;

  rtc_trim_stage #(
    .P_W(P_W), .Q_W(Q_W), .P_RESET(P_RESET), .P_MIN(P_MIN)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .sec_end(sec_end), .trim_load(trim_load),
    .trim_p(trim_p), .trim_q(trim_q), .act_p(act_p), .act_q(act_q)
  );

  rtc_quarter_count #(
    .P_W(P_W), .Q_W(Q_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .ce(ce), .act_p(act_p), .act_q(act_q),
    .qtr_idx(qtr_idx), .qtr_end(qtr_end), .sec_end(sec_end)
  );

  rtc_cal_out #(
    .Q_W(Q_W), .G_W(G_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .qtr_end(qtr_end), .sec_end(sec_end),
    .qtr_idx(qtr_idx), .qtr_tick(qtr_tick), .sec_tick(sec_tick),
    .pulse_1s(pulse_1s), .pulse_4s(pulse_4s)
  );

endmodule

// File: rtl/rtc_trim_divider_sva.sv
module rtc_trim_divider_sva #(
  parameter int unsigned P_W   = 17,
  parameter int unsigned Q_W   = 2,
  parameter int unsigned P_MIN = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce,
  input logic           qtr_tick,
  input logic           sec_tick,
  input logic           pulse_1s,
  input logic           pulse_4s,
  input logic [P_W-1:0] act_p,
  input logic [Q_W-1:0] act_q,
  input logic           qtr_end
);

  a_r2_no_tick_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !qtr_tick);

  a_r3_event_reaches_port: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_end |=> qtr_tick);

  a_r4_sec_with_qtr: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> qtr_tick);

  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |=> !qtr_tick);

  a_r5_trim_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_p) || !$stable(act_q)) |-> sec_tick);

  a_r6_pulse1s_starts_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_1s) |-> sec_tick);

  a_r7_pulse4s_moves_on_second: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_4s) |-> sec_tick);

  a_r8_p_floor: assert property (@(posedge clk) disable iff (!rst_n)
    act_p >= P_W'(P_MIN));

endmodule

bind rtc_trim_divider rtc_trim_divider_sva #(
  .P_W(P_W), .Q_W(Q_W), .P_MIN(P_MIN)
) u_sva (
  .clk(clk), .rst_n(rst_n), .ce(ce), .qtr_tick(qtr_tick), .sec_tick(sec_tick),
  .pulse_1s(pulse_1s), .pulse_4s(pulse_4s), .act_p(act_p), .act_q(act_q),
  .qtr_end(qtr_end)
);

// File: tb/rtc_trim_divider_test.sv
module rtc_trim_divider_test;

  localparam int CLK_PERIOD = 10;
  localparam int FAST_P0    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  // default-parameter instance, used for the reset state
  logic        ce_a = 1'b0;
  logic        sec_a, qtr_a, p1_a, p4_a;
  // short-second instance, compared against the reference every clock
  logic        ce_b = 1'b0;
  logic        ld_b = 1'b0;
  logic [16:0] tp_b = '0;
  logic [1:0]  tq_b = '0;
  logic        sec_b, qtr_b, p1_b, p4_b;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_trim_divider uut (
    .clk(clk), .rst_n(rst_n), .ce(ce_a), .trim_load(1'b0), .trim_p(17'd0),
    .trim_q(2'd0), .sec_tick(sec_a), .qtr_tick(qtr_a), .pulse_1s(p1_a), .pulse_4s(p4_a)
  );

  rtc_trim_divider #(.P_RESET(17'(FAST_P0))) uut_fast (
    .clk(clk), .rst_n(rst_n), .ce(ce_b), .trim_load(ld_b), .trim_p(tp_b),
    .trim_q(tq_b), .sec_tick(sec_b), .qtr_tick(qtr_b), .pulse_1s(p1_b), .pulse_4s(p4_b)
  );

  // ---------------- reference model ----------------
  int m_p, m_q, pend_p, pend_q, m_pos, m_qtr, m_grp;
  bit e_qtr, e_sec;

  function automatic int floor_p(input int p);
    return (p < 4) ? 4 : p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p = FAST_P0; m_q = 0; pend_p = FAST_P0; pend_q = 0;
      m_pos = 0; m_qtr = 0; m_grp = 0; e_qtr = 0; e_sec = 0;
    end else begin
      int acc;
      bit closes;
      e_qtr = 0; e_sec = 0; closes = 0;
      if (ce_b) begin
        m_pos++;
        acc = 0;
        for (int k = 0; k < 4; k++) begin
          acc += m_p + ((k < m_q) ? 1 : 0);
          if (m_pos == acc) begin
            e_qtr = 1;
            m_qtr = (k + 1) % 4;
            if (k == 3) closes = 1;
          end
        end
      end
      if (closes) begin
        e_sec = 1;
        m_pos = 0;
        m_grp = (m_grp + 1) % 4;
        if (ld_b) begin m_p = floor_p(int'(tp_b)); m_q = int'(tq_b); end
        else      begin m_p = pend_p; m_q = pend_q; end
      end
      if (ld_b) begin pend_p = floor_p(int'(tp_b)); pend_q = int'(tq_b); end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (qtr_b !== e_qtr) begin
        failures++;
        $display("FAIL R3 qtr_tick actual=%0b expected=%0b t=%0t", qtr_b, e_qtr, $time);
      end else if (sec_b !== e_sec) begin
        failures++;
        $display("FAIL R4 sec_tick actual=%0b expected=%0b t=%0t", sec_b, e_sec, $time);
      end else if (p1_b !== (m_qtr == 0)) begin
        failures++;
        $display("FAIL R6 pulse_1s actual=%0b expected=%0b t=%0t", p1_b, m_qtr == 0, $time);
      end else if (p4_b !== (m_grp == 0)) begin
        failures++;
        $display("FAIL R7 pulse_4s actual=%0b expected=%0b t=%0t", p4_b, m_grp == 0, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ce_b = (mode == 0) ? 1'b1 : (((i * 5) % 7) < 4);
    end
  endtask

  task automatic load(input int p, input int q);
    @(negedge clk);
    ld_b = 1'b1; tp_b = 17'(p); tq_b = 2'(q);
    @(negedge clk);
    ld_b = 1'b0;
  endtask

  // with ce held at 1, returns the clocks between two sec_tick pulses
  task automatic measure(output int len);
    int guard = 0;
    ce_b = 1'b1;
    do begin @(negedge clk); guard++; end while (!sec_b && guard < 2000);
    len = 0;
    do begin @(negedge clk); len++; end while (!sec_b && len < 2000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int first, len;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports (no ce yet)
    check(qtr_a == 0 && sec_a == 0, "R1 ticks after reset", {qtr_a, sec_a}, 0);
    check(p1_a == 1 && p4_a == 1, "R1 pulses after reset", {p1_a, p4_a}, 3);
    // R1: default trim gives 65536 cycles in the first quarter
    ce_a = 1'b1;
    first = 0;
    for (int i = 1; i <= 65540; i++) begin
      @(negedge clk);
      if (qtr_a && first == 0) first = i;
    end
    ce_a = 1'b0;
    check(first == 65536, "R1 first quarter length", first, 65536);
    check(sec_a == 0 && p1_a == 0 && p4_a == 1, "R1 state after quarter 0",
          {sec_a, p1_a, p4_a}, 1);

    // main comparison on the short-second instance
    cmp_on = 1'b1;
    run(60, 0);
    load(5, 2);                     // R5 staged mid-second
    run(120, 0);
    run(150, 1);
    measure(len);
    check(len == 22, "R3 second with P=5 Q=2", len, 22);

    load(1, 0);                     // R8 raised to P=4
    run(40, 0);
    measure(len);
    check(len == 16, "R8 clamped second length", len, 16);

    load(7, 3);
    run(40, 1);
    measure(len);
    check(len == 31, "R3 second with P=7 Q=3", len, 31);

    // R5: load issued in the boundary cycle applies at that boundary
    ce_b = 1'b1;
    do @(negedge clk); while (m_pos != 4 * m_p + m_q - 1);
    ld_b = 1'b1; tp_b = 17'd9; tq_b = 2'd1;
    @(negedge clk);
    ld_b = 1'b0;
    check(sec_b == 1, "R5 boundary tick at load", sec_b, 1);
    len = 0;
    do begin @(negedge clk); len++; end while (!sec_b && len < 2000);
    check(len == 37, "R5 load at boundary applies at once", len, 37);

    // R5: several loads in one second, last one wins
    load(10, 0);
    load(12, 0);
    measure(len);
    measure(len);
    check(len == 48, "R5 last load wins", len, 48);

    // R2: no progress while ce is low
    ce_b = 1'b0;
    @(negedge clk);
    seen = 0;
    len = {p1_b, p4_b};
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (qtr_b || sec_b || ({p1_b, p4_b} != 2'(len))) seen = 1;
    end
    check(!seen, "R2 frozen while ce low", seen, 0);

    load(4, 3);
    run(400, 1);
    run(100, 0);
    cmp_on = 1'b0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule